// File: doc/BRIEF.md
# Shared Memory Swizzle Address Mapper

This block turns a linear destination byte address into the address where the byte is placed in a swizzled shared-memory buffer. Memory is viewed as 128-byte lines. Each line holds eight 16-byte chunks. The mapper permutes the 3-bit chunk index inside each line. The permutation key comes from the line number plus a base offset, and the base offset is taken from the buffer's start address. The shape of the key depends on the swizzle period (none, 32, 64, 96 or 128 bytes) and, in 128-byte mode, on the atomicity: chunks may move as units of 16, 32 or 64 bytes, or as 32-byte units with an extra swap of 8-byte halves on alternate lines. The mapper also reports that half swap. It flags mode combinations that are not allowed and start addresses that are not aligned enough for the selected atomicity.

Requests enter through a valid/ready port and results leave through another. The result is computed combinationally. A parameter chooses between a direct connection and a one-entry register slice at the output. In the registered build, `in_ready` is high whenever the slice is empty or the consumer takes the current result in the same cycle. A result held with `out_ready` low stays stable until it is taken, and no request is accepted while it waits. The mode, atomicity, start address and direction signals travel with each request and are sampled on the same handshake.

Top module: `swz_addr_mapper`

## Requirements
- R1: With `in_mode`=0 (no swizzle), the output address equals the input address and no error is flagged.
- R2: With `in_mode`=4 (128-byte) and `in_atom`=0 (16-byte units), the chunk field address[6:4] is XORed with (line + base) mod 8, where line = address[17:7].
- R3: With `in_mode`=2 (64-byte), the chunk field is XORed with (line + base) mod 4.
- R4: With `in_mode`=1 (32-byte) or `in_mode`=3 (96-byte), the chunk field is XORed with (line + base) mod 2.
- R5: The base is start[9:7], reduced modulo 8, 4 or 2 to match the mode's period, and it is added to the line before the XOR.
- R6: With `in_mode`=4 and `in_atom`=1 (32-byte units), the chunk field is XORed with 2·((line + base) mod 4), and a start address with start[4:0] ≠ 0 flags a misalignment.
- R7: With `in_mode`=4 and `in_atom`=3 (64-byte units), the chunk field is XORed with 4·((line + base) mod 2), and a start address with start[5:0] ≠ 0 flags a misalignment.
- R8: With `in_mode`=4, `in_atom`=2 and `in_g2s`=1, the R6 permutation applies. In addition, address bit 3 is inverted and `out_flip` is set whenever (line + base) is odd. `out_flip` is never set in any other case.
- R9: A configuration error is flagged, and the address passes through unchanged, when `in_mode` is above 4, when `in_atom` ≠ 0 is combined with any mode other than 4, or when `in_atom`=2 is used with `in_g2s`=0.
- R10: `out_align_err` is set only for the 32-byte, flipped or 64-byte atomicities, in the cases given in R6 and R7. The mapped address is still produced.
- R11: With the output register enabled, a result waiting with `out_ready` low keeps its value and `out_valid`, and `in_ready` stays low until the result is taken.
- R12: Address bits [17:7] and [2:0] are never changed by the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_addr | input | 18 | Linear destination byte address |
| in_start | input | 18 | Buffer start address, used for the base offset and the alignment check |
| in_mode | input | 3 | Swizzle period: 0 none, 1 32B, 2 64B, 3 96B, 4 128B |
| in_atom | input | 2 | Atomicity: 0 16B, 1 32B, 2 32B with 8-byte flip, 3 64B |
| in_g2s | input | 1 | High when the copy runs from global to shared memory |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 18 | Swizzled byte address |
| out_flip | output | 1 | 8-byte halves swapped for this address |
| out_cfg_err | output | 1 | Illegal mode combination |
| out_align_err | output | 1 | Start address not aligned enough for the atomicity |

## Verification
On every cycle, the assertions check the rules that hold for any address: the identity mapping in no-swizzle mode, the preservation of the line and low byte bits, the conditions under which the flip can appear, the error flag for illegal combinations, the fixed 64-byte halves under 64-byte atomicity, and stability of a held result under back-pressure. The exact XOR key for each period, the effect of the base offset, and which chunk a given address lands in can only be shown by the bench. Its vectors are worked out by hand, as are the stall-and-release sequence on the output handshake.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int CHUNK_LSB = 4;
  localparam int CHUNK_W   = 3;
  localparam int LINE_LSB  = CHUNK_LSB + CHUNK_W;

  typedef enum logic [2:0] {
    SWZ_NONE = 3'd0,
    SWZ_32   = 3'd1,
    SWZ_64   = 3'd2,
    SWZ_96   = 3'd3,
    SWZ_128  = 3'd4
  } swz_mode_e;

  typedef enum logic [1:0] {
    ATOM_16  = 2'd0,
    ATOM_32  = 2'd1,
    ATOM_32F = 2'd2,
    ATOM_64  = 2'd3
  } swz_atom_e;

  function automatic logic [CHUNK_W-1:0] period_mask(swz_mode_e m);
    case (m)
      SWZ_128:        return 3'b111;
      SWZ_64:         return 3'b011;
      SWZ_32, SWZ_96: return 3'b001;
      default:        return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/swz_cfg_check.sv
module swz_cfg_check
  import swz_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic [2:0]    mode,
  input  logic [1:0]    atom,
  input  logic          g2s,
  input  logic [AW-1:0] start,
  output logic          cfg_err,
  output logic          align_err
);
  swz_mode_e m;
  swz_atom_e a;
  logic mode_bad, atom_bad, dir_bad;

  assign m = swz_mode_e'(mode);
  assign a = swz_atom_e'(atom);

  always_comb begin
    mode_bad = (mode > 3'd4);
    atom_bad = (a != ATOM_16) && (m != SWZ_128);
    dir_bad  = (a == ATOM_32F) && !g2s;
    cfg_err  = mode_bad || atom_bad || dir_bad;
  end

  always_comb begin
    align_err = 1'b0;
    if (!cfg_err) begin
      case (a)
        ATOM_32, ATOM_32F: align_err = (start[4:0] != 5'd0);
        ATOM_64:           align_err = (start[5:0] != 6'd0);
        default:           align_err = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/swz_key_gen.sv
module swz_key_gen
  import swz_pkg::*;
(
  input  logic [2:0]         mode,
  input  logic [1:0]         atom,
  input  logic [CHUNK_W-1:0] line_lo,
  input  logic [CHUNK_W-1:0] base_raw,
  output logic [CHUNK_W-1:0] key,
  output logic               flip
);
  swz_mode_e          m;
  swz_atom_e          a;
  logic [CHUNK_W-1:0] msk;
  logic [CHUNK_W-1:0] sum;

  assign m   = swz_mode_e'(mode);
  assign a   = swz_atom_e'(atom);
  assign msk = period_mask(m);
  assign sum = line_lo + (base_raw & msk);

  always_comb begin
    key  = '0;
    flip = 1'b0;
    if (m == SWZ_128) begin
      case (a)
        ATOM_16:  key = sum;
        ATOM_32:  key = {sum[1:0], 1'b0};
        ATOM_32F: begin
          key  = {sum[1:0], 1'b0};
          flip = sum[0];
        end
        default:  key = {sum[0], 2'b00};
      endcase
    end else begin
      key = sum & msk;
    end
  end
endmodule

// File: rtl/swz_out_stage.sv
module swz_out_stage #(
  parameter int W       = 21,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) d_q <= in_data;
        end
      end
      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;
    end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/swz_addr_mapper.sv
module swz_addr_mapper
  import swz_pkg::*;
#(
  parameter int AW      = 18,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [AW-1:0] in_start,
  input  logic [2:0]    in_mode,
  input  logic [1:0]    in_atom,
  input  logic          in_g2s,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_flip,
  output logic          out_cfg_err,
  output logic          out_align_err
);
  localparam int PW = AW + 3;

  logic [CHUNK_W-1:0] key;
  logic               key_flip;
  logic               cfg_err;
  logic               aln_err;
  logic [AW-1:0]      map_addr;
  logic               map_flip;
  logic [PW-1:0]      pay_in;
  logic [PW-1:0]      pay_out;

  swz_key_gen u_key (
    .mode     (in_mode),
    .atom     (in_atom),
    .line_lo  (in_addr[LINE_LSB +: CHUNK_W]),
    .base_raw (in_start[LINE_LSB +: CHUNK_W]),
    .key      (key),
    .flip     (key_flip)
  );

  swz_cfg_check #(.AW(AW)) u_cfg (
    .mode      (in_mode),
    .atom      (in_atom),
    .g2s       (in_g2s),
    .start     (in_start),
    .cfg_err   (cfg_err),
    .align_err (aln_err)
  );

  always_comb begin
    map_addr = in_addr;
    map_flip = 1'b0;
    if (!cfg_err) begin
      map_addr[CHUNK_LSB +: CHUNK_W] = in_addr[CHUNK_LSB +: CHUNK_W] ^ key;
      map_addr[CHUNK_LSB-1]          = in_addr[CHUNK_LSB-1] ^ key_flip;
      map_flip                       = key_flip;
    end
  end

  assign pay_in = {map_addr, map_flip, cfg_err, aln_err};

  swz_out_stage #(.W(PW), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_addr, out_flip, out_cfg_err, out_align_err} = pay_out;
endmodule

// File: rtl/swz_mapper_chk.sv
module swz_mapper_chk #(
  parameter int AW      = 18,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] in_addr,
  input logic [2:0]    in_mode,
  input logic [1:0]    in_atom,
  input logic          in_g2s,
  input logic [AW-1:0] map_addr,
  input logic          map_flip,
  input logic          cfg_err,
  input logic          out_valid,
  input logic          out_ready,
  input logic          in_ready,
  input logic [AW-1:0] out_addr
);
  assert_identity_R1: assert property (@(posedge clk) disable iff (rst)
    (in_mode == 3'd0 && in_atom == 2'd0) |-> (map_addr == in_addr && !cfg_err));

  assert_keep_bits_R12: assert property (@(posedge clk) disable iff (rst)
    (map_addr[AW-1:7] == in_addr[AW-1:7]) && (map_addr[2:0] == in_addr[2:0]));

  assert_flip_only_R8: assert property (@(posedge clk) disable iff (rst)
    map_flip |-> (in_mode == 3'd4 && in_atom == 2'd2 && in_g2s));

  assert_cfg_err_R9: assert property (@(posedge clk) disable iff (rst)
    ((in_mode > 3'd4) || (in_atom != 2'd0 && in_mode != 3'd4)) |-> (cfg_err && map_addr == in_addr));

  assert_half_swap_R7: assert property (@(posedge clk) disable iff (rst)
    (in_mode == 3'd4 && in_atom == 2'd3) |-> (map_addr[5:0] == in_addr[5:0]));

  generate
    if (REG_OUT) begin : g_hold
      assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));
      assert_stall_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);
    end
  endgenerate
endmodule

bind swz_addr_mapper swz_mapper_chk #(.AW(AW), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_addr   (in_addr),
  .in_mode   (in_mode),
  .in_atom   (in_atom),
  .in_g2s    (in_g2s),
  .map_addr  (map_addr),
  .map_flip  (map_flip),
  .cfg_err   (cfg_err),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .in_ready  (in_ready),
  .out_addr  (out_addr)
);

// File: tb/sim_swz_addr_mapper.sv
module sim_swz_addr_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [17:0] in_addr = '0;
  logic [17:0] in_start = '0;
  logic [2:0]  in_mode = '0;
  logic [1:0]  in_atom = '0;
  logic        in_g2s = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [17:0] out_addr;
  logic        out_flip;
  logic        out_cfg_err;
  logic        out_align_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  swz_addr_mapper u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_start(in_start),
    .in_mode(in_mode), .in_atom(in_atom), .in_g2s(in_g2s),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_flip(out_flip),
    .out_cfg_err(out_cfg_err), .out_align_err(out_align_err)
  );

  // {mode, atom, g2s, start, addr, exp_addr, exp_flip, exp_cfg, exp_aln}
  localparam int NV = 16;
  localparam logic [62:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b0, 18'h00000, 18'h00A35, 18'h00A35, 1'b0, 1'b0, 1'b0},
    {3'd4, 2'd0, 1'b0, 18'h00000, 18'h00195, 18'h001A5, 1'b0, 1'b0, 1'b0},
    {3'd4, 2'd0, 1'b0, 18'h00080, 18'h00195, 18'h001D5, 1'b0, 1'b0, 1'b0},
    {3'd2, 2'd0, 1'b0, 18'h00000, 18'h002E0, 18'h002F0, 1'b0, 1'b0, 1'b0},
    {3'd1, 2'd0, 1'b0, 18'h00180, 18'h00149, 18'h00159, 1'b0, 1'b0, 1'b0},
    {3'd3, 2'd0, 1'b0, 18'h00000, 18'h00380, 18'h00390, 1'b0, 1'b0, 1'b0},
    {3'd4, 2'd1, 1'b0, 18'h00000, 18'h00195, 18'h001F5, 1'b0, 1'b0, 1'b0},
    {3'd4, 2'd3, 1'b0, 18'h00000, 18'h000A0, 18'h000E0, 1'b0, 1'b0, 1'b0},
    {3'd4, 2'd2, 1'b1, 18'h00000, 18'h000A3, 18'h0008B, 1'b1, 1'b0, 1'b0},
    {3'd4, 2'd2, 1'b1, 18'h00000, 18'h0012B, 18'h0016B, 1'b0, 1'b0, 1'b0},
    {3'd4, 2'd2, 1'b0, 18'h00000, 18'h000A3, 18'h000A3, 1'b0, 1'b1, 1'b0},
    {3'd2, 2'd1, 1'b0, 18'h00000, 18'h002E0, 18'h002E0, 1'b0, 1'b1, 1'b0},
    {3'd5, 2'd0, 1'b0, 18'h00000, 18'h00195, 18'h00195, 1'b0, 1'b1, 1'b0},
    {3'd4, 2'd1, 1'b0, 18'h00010, 18'h00195, 18'h001F5, 1'b0, 1'b0, 1'b1},
    {3'd4, 2'd3, 1'b0, 18'h00020, 18'h000A0, 18'h000E0, 1'b0, 1'b0, 1'b1},
    {3'd4, 2'd1, 1'b0, 18'h00020, 18'h000A0, 18'h00080, 1'b0, 1'b0, 1'b0}
  };
  localparam string TAG [NV] = '{
    "R1", "R2", "R5", "R3", "R4", "R4", "R6", "R7",
    "R8", "R8", "R9", "R9", "R9", "R10", "R10", "R6"
  };

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [62:0] v);
    in_mode  = v[62:60];
    in_atom  = v[59:58];
    in_g2s   = v[57];
    in_start = v[56:39];
    in_addr  = v[38:21];
    in_valid = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state, R11
    check("R11 reset", {19'd0, out_valid, in_ready}, {19'd0, 1'b0, 1'b1});

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(TAG[i], {out_addr, out_flip, out_cfg_err, out_align_err}, VEC[i][20:0]);
      check(TAG[i], {20'd0, out_valid}, 21'd1);
      // R12: line and low byte bits untouched
      check("R12", {3'd0, out_addr[17:7], out_addr[2:0], 4'd0},
                   {3'd0, VEC[i][38:28], VEC[i][23:21], 4'd0});
    end

    // R11 back-pressure: hold result, stall input, then release
    @(negedge clk);
    out_ready = 1'b0;
    drive(VEC[1]);
    @(posedge clk);
    @(negedge clk);
    drive(VEC[3]);
    check("R11 stall", {19'd0, out_valid, in_ready}, {19'd0, 1'b1, 1'b0});
    @(posedge clk);
    @(negedge clk);
    check("R11 hold", {out_addr, 3'd0}, {18'h001A5, 3'd0});
    check("R11 still stalled", {20'd0, in_ready}, 21'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 release", {out_addr, 2'd0, out_valid}, {18'h002F0, 2'd0, 1'b1});
    @(posedge clk);
    @(negedge clk);
    check("R11 drained", {20'd0, out_valid}, 21'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule